// File: doc/BRIEF.md
# Multicycle Five-Step Integer Core

This block is a small, non-pipelined 32-bit integer core for a load/store instruction subset. Every instruction is carried through a fixed sequence of steps: fetch, decode with register read, execute or address forming, memory access or branch completion, and write-back. Internal latches keep the fetched instruction, the sequential next address, two register operands, the sign-extended immediate, the branch condition, the ALU result and the loaded word. Each step reads only what earlier steps latched.

The core drives an instruction port and a data port, both reached through plain address/data lines. Reads are combinational within the cycle and the data write happens on the clock edge at the end of the write-enable cycle. The subset covers word loads, word stores, register-register ALU operations, register-immediate ALU operations and a branch taken when one register equals zero. A branch computes its target and condition in the execute step; the program counter is committed only in the memory step.

The step sequencer is a five-state machine. States: `ST_FETCH`, `ST_DECODE`, `ST_EXEC`, `ST_MEM`, `ST_WB`. Transitions: reset puts it in `ST_FETCH`; `ST_FETCH` to `ST_DECODE` to `ST_EXEC` to `ST_MEM` always; `ST_MEM` to `ST_WB` for instructions that write a register (loads, register-register, register-immediate); `ST_MEM` to `ST_FETCH` for stores, branches and unrecognised words; `ST_WB` to `ST_FETCH` always.

Top module: `mc_core`

## Requirements
- R1: In the fetch step the instruction word at the current PC is latched and the sequential address PC + 4 is kept; an instruction that is not a taken branch leaves PC + 4 as the next PC.
- R2: In the decode step operand A is read from the register in bits 25:21, operand B from the register in bits 20:16, and the immediate is bits 15:0 sign-extended to 32 bits.
- R3: A load (opcode 0x10) or store (opcode 0x11) uses the address A + immediate.
- R4: Opcode 0x00 is register-register with the function in bits 5:0: 0x00 add, 0x01 subtract, 0x02 and, 0x03 or, 0x04 xor, 0x05 signed set-less-than. Register-immediate opcodes apply A with the immediate: 0x01 add, 0x02 signed set-less-than, 0x03 and, 0x04 or, 0x05 xor.
- R5: The branch (opcode 0x12) has target (PC + 4) + (immediate << 2) and is taken when A equals zero; the PC changes only at the end of the memory step.
- R6: In the memory step a load latches the data word at its address; a store drives B on the write data with the write enable high for exactly one cycle, the fourth cycle of the instruction.
- R7: In the write-back step a register-register result goes to the register in bits 15:11; a register-immediate result or load data goes to the register in bits 20:16.
- R8: Stores, branches and unrecognised words take four clocks; loads, register-register and register-immediate operations take five.
- R9: Register 0 always reads as zero; writes to it are dropped.
- R10: Synchronous active-high reset sets PC to 0, clears all registers, selects the fetch step and holds the data write enable low.
- R11: Any other opcode, or opcode 0x00 with a function above 0x05, writes no register and no memory and advances PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction address (current PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Data address (ALU result latch) |
| dmem_wdata | output | 32 | Store data (operand B) |
| dmem_we | output | 1 | Data write enable, one cycle per store |
| dmem_rdata | input | 32 | Data word at dmem_addr, same cycle |

## Verification
A directed prologue runs a countdown loop with a backward taken branch and a forward taken branch, a write to register 0 stored back out, a negative immediate, a load with a negative offset whose result feeds the very next instruction, and an unrecognised word; together these separate taken from untaken branches, sign extension from zero extension, and a dropped register-0 write from a kept one. The bulk is a seeded random mix of all operations on a small register set with short forward branches, followed by stores of every used register, so a wrong operand, function, destination field or loaded word shows up in a stored value. Every instruction is tracked in lockstep against a bench model: the PC at each fetch and the cycle of every write enable are predicted, so a four-versus-five clock error or a PC committed in the wrong step shifts the whole trace.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN    = 32;
    localparam int REG_CNT = 32;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEM,
        ST_WB
    } step_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_LOAD,
        K_STORE,
        K_REGREG,
        K_REGIMM,
        K_BRZ
    } kind_e;

    typedef enum logic [2:0] {
        F_ADD,
        F_SUB,
        F_AND,
        F_OR,
        F_XOR,
        F_SLT
    } fn_e;

    // opcode field, bits 31:26
    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_ADDI = 6'h01;
    localparam logic [5:0] OPC_SLTI = 6'h02;
    localparam logic [5:0] OPC_ANDI = 6'h03;
    localparam logic [5:0] OPC_ORI  = 6'h04;
    localparam logic [5:0] OPC_XORI = 6'h05;
    localparam logic [5:0] OPC_LOAD = 6'h10;
    localparam logic [5:0] OPC_STOR = 6'h11;
    localparam logic [5:0] OPC_BRZ  = 6'h12;

    // function field, bits 5:0, for OPC_REG
    localparam logic [5:0] FN_ADD = 6'h00;
    localparam logic [5:0] FN_SUB = 6'h01;
    localparam logic [5:0] FN_AND = 6'h02;
    localparam logic [5:0] FN_OR  = 6'h03;
    localparam logic [5:0] FN_XOR = 6'h04;
    localparam logic [5:0] FN_SLT = 6'h05;

    typedef struct packed {
        kind_e      kind;
        fn_e        fn;
        logic [4:0] src_a;
        logic [4:0] src_b;
        logic [4:0] dest;
        logic       wb;
    } dec_t;

endpackage

// File: rtl/mc_decode.sv
module mc_decode
    import mc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);

    logic [5:0] opc;
    logic [5:0] fcode;

    assign opc   = instr[31:26];
    assign fcode = instr[5:0];

    always_comb begin
        dec.src_a = instr[25:21];
        dec.src_b = instr[20:16];
        dec.dest  = instr[20:16];
        dec.kind  = K_NONE;
        dec.fn    = F_ADD;
        dec.wb    = 1'b0;
        unique case (opc)
            OPC_REG: begin
                dec.dest = instr[15:11];
                dec.kind = K_REGREG;
                dec.wb   = 1'b1;
                unique case (fcode)
                    FN_ADD:  dec.fn = F_ADD;
                    FN_SUB:  dec.fn = F_SUB;
                    FN_AND:  dec.fn = F_AND;
                    FN_OR:   dec.fn = F_OR;
                    FN_XOR:  dec.fn = F_XOR;
                    FN_SLT:  dec.fn = F_SLT;
                    default: begin
                        dec.kind = K_NONE;
                        dec.wb   = 1'b0;
                    end
                endcase
            end
            OPC_ADDI: begin dec.kind = K_REGIMM; dec.fn = F_ADD; dec.wb = 1'b1; end
            OPC_SLTI: begin dec.kind = K_REGIMM; dec.fn = F_SLT; dec.wb = 1'b1; end
            OPC_ANDI: begin dec.kind = K_REGIMM; dec.fn = F_AND; dec.wb = 1'b1; end
            OPC_ORI:  begin dec.kind = K_REGIMM; dec.fn = F_OR;  dec.wb = 1'b1; end
            OPC_XORI: begin dec.kind = K_REGIMM; dec.fn = F_XOR; dec.wb = 1'b1; end
            OPC_LOAD: begin dec.kind = K_LOAD;   dec.wb = 1'b1; end
            OPC_STOR: dec.kind = K_STORE;
            OPC_BRZ:  dec.kind = K_BRZ;
            default:  dec.kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  fn_e          fn,
    input  logic [W-1:0] opx,
    input  logic [W-1:0] opy,
    output logic [W-1:0] res
);

    always_comb begin
        unique case (fn)
            F_ADD:   res = opx + opy;
            F_SUB:   res = opx - opy;
            F_AND:   res = opx & opy;
            F_OR:    res = opx | opy;
            F_XOR:   res = opx ^ opy;
            F_SLT:   res = {{(W-1){1'b0}}, ($signed(opx) < $signed(opy))};
            default: res = opx + opy;
        endcase
    end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = REG_CNT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [$clog2(N)-1:0] rsel_a,
    input  logic [$clog2(N)-1:0] rsel_b,
    output logic [W-1:0]         rval_a,
    output logic [W-1:0]         rval_b,
    input  logic                 wen,
    input  logic [$clog2(N)-1:0] wsel,
    input  logic [W-1:0]         wval
);

    localparam int AW = $clog2(N);

    logic [W-1:0] cells [N];

    // entry 0 is a constant zero; the rest are writable cells
    assign cells[0] = '0;

    for (genvar g = 1; g < N; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[g] <= '0;
            end else if (wen && (wsel == AW'(g))) begin
                cells[g] <= wval;
            end
        end
    end

    assign rval_a = cells[rsel_a];
    assign rval_b = cells[rsel_b];

endmodule

// File: rtl/mc_seq.sv
module mc_seq
    import mc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wb_need,
    output step_e step,
    output logic  en_fetch,
    output logic  en_decode,
    output logic  en_exec,
    output logic  en_mem,
    output logic  en_wb
);

    step_e step_q;
    step_e step_d;

    always_comb begin
        step_d = step_q;
        unique case (step_q)
            ST_FETCH:  step_d = ST_DECODE;
            ST_DECODE: step_d = ST_EXEC;
            ST_EXEC:   step_d = ST_MEM;
            ST_MEM:    step_d = wb_need ? ST_WB : ST_FETCH;
            ST_WB:     step_d = ST_FETCH;
            default:   step_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= ST_FETCH;
        else     step_q <= step_d;
    end

    always_comb begin
        en_fetch  = 1'b0;
        en_decode = 1'b0;
        en_exec   = 1'b0;
        en_mem    = 1'b0;
        en_wb     = 1'b0;
        unique case (step_q)
            ST_FETCH:  en_fetch  = 1'b1;
            ST_DECODE: en_decode = 1'b1;
            ST_EXEC:   en_exec   = 1'b1;
            ST_MEM:    en_mem    = 1'b1;
            ST_WB:     en_wb     = 1'b1;
            default:   en_fetch  = 1'b0;
        endcase
    end

    assign step = step_q;

    // R10
    reset_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (step_q == ST_FETCH));

    // R8
    short_instr_chk: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_MEM && !wb_need) |=> (step_q == ST_FETCH));

    // R8
    wb_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_WB) |=> (step_q == ST_FETCH));

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int NREG = REG_CNT
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam int RAW = $clog2(NREG);
    localparam logic [XLEN-1:0] STEP4 = XLEN'(4);

    step_e step;
    logic  en_fetch, en_decode, en_exec, en_mem, en_wb;

    logic [XLEN-1:0] pc_q, npc_q, ir_q, a_q, b_q, imm_q, alu_q, lmd_q;
    logic            cond_q;

    dec_t            dec;
    logic [XLEN-1:0] rf_a, rf_b, rf_wval;
    logic [XLEN-1:0] alu_x, alu_y, alu_res;
    logic [XLEN-1:0] imm_ext;

    mc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .wb_need   (dec.wb),
        .step      (step),
        .en_fetch  (en_fetch),
        .en_decode (en_decode),
        .en_exec   (en_exec),
        .en_mem    (en_mem),
        .en_wb     (en_wb)
    );

    mc_decode u_dec (
        .instr (ir_q),
        .dec   (dec)
    );

    mc_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .rsel_a (RAW'(dec.src_a)),
        .rsel_b (RAW'(dec.src_b)),
        .rval_a (rf_a),
        .rval_b (rf_b),
        .wen    (en_wb),
        .wsel   (RAW'(dec.dest)),
        .wval   (rf_wval)
    );

    // operand selection for the execute step
    always_comb begin
        alu_x = a_q;
        alu_y = imm_q;
        unique case (dec.kind)
            K_REGREG: alu_y = b_q;
            K_BRZ: begin
                alu_x = npc_q;
                alu_y = imm_q << 2;
            end
            default: alu_y = imm_q;
        endcase
    end

    mc_alu #(.W(XLEN)) u_alu (
        .fn  (dec.fn),
        .opx (alu_x),
        .opy (alu_y),
        .res (alu_res)
    );

    assign imm_ext = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
    assign rf_wval = (dec.kind == K_LOAD) ? lmd_q : alu_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            npc_q  <= '0;
            ir_q   <= '0;
            a_q    <= '0;
            b_q    <= '0;
            imm_q  <= '0;
            alu_q  <= '0;
            lmd_q  <= '0;
            cond_q <= 1'b0;
        end else begin
            if (en_fetch) begin
                ir_q  <= imem_rdata;
                npc_q <= pc_q + STEP4;
            end
            if (en_decode) begin
                a_q   <= rf_a;
                b_q   <= rf_b;
                imm_q <= imm_ext;
            end
            if (en_exec) begin
                alu_q  <= alu_res;
                cond_q <= (a_q == '0);
            end
            if (en_mem) begin
                pc_q <= (dec.kind == K_BRZ && cond_q) ? alu_q : npc_q;
                if (dec.kind == K_LOAD) lmd_q <= dmem_rdata;
            end
        end
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_q;
    assign dmem_wdata = b_q;
    assign dmem_we    = en_mem && (dec.kind == K_STORE);

    // R1
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step != ST_MEM) |=> $stable(pc_q));

    // R5
    branch_take_chk: assert property (@(posedge clk) disable iff (rst)
        (step == ST_MEM && dec.kind == K_BRZ && cond_q) |=> (pc_q == $past(alu_q)));

    // R6
    store_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> !dmem_we);

    // R10
    reset_pc_chk: assert property (@(posedge clk)
        rst |=> (pc_q == '0));

endmodule

// File: tb/tb_mc_core.sv
`timescale 1ns/1ps
module tb_mc_core;

    localparam int MW   = 256;
    localparam int HALT = 207;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [MW];
    logic [31:0] dmem [MW];
    logic [31:0] mdm  [MW];
    logic [31:0] mrg  [32];
    logic [31:0] mpc;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit dog   = 0;

    always #2.5 clk = ~clk;

    mc_core dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[9:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
        cyc <= cyc + 1;
    end

    function automatic logic [31:0] enc_r(int fn, int rd, int rs, int rt);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(int op, int rt, int rs, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] ref_alu(int fn, logic [31:0] x, logic [31:0] y);
        case (fn)
            0: return x + y;
            1: return x - y;
            2: return x & y;
            3: return x | y;
            4: return x ^ y;
            default: return {31'd0, $signed(x) < $signed(y)};
        endcase
    endfunction

    function automatic void put_reg(int d, logic [31:0] v);
        if (d != 0) mrg[d] = v;  // R9 register 0 never changes
    endfunction

    // bench model of one instruction, computed from the requirements
    task automatic model_step(output int n, output bit st,
                              output logic [31:0] sa, output logic [31:0] sd,
                              output string tag);
        logic [31:0] ir, a, b, imm, npc, nxt;
        int op, rs, rt, rd, fn;
        ir  = imem[mpc[9:2]];
        op  = int'(ir[31:26]);
        rs  = int'(ir[25:21]);
        rt  = int'(ir[20:16]);
        rd  = int'(ir[15:11]);
        fn  = int'(ir[5:0]);
        imm = {{16{ir[15]}}, ir[15:0]};
        a   = mrg[rs];
        b   = mrg[rt];
        npc = mpc + 32'd4;
        nxt = npc;
        n   = 4;
        st  = 0;
        sa  = '0;
        sd  = '0;
        tag = "R1/R11";
        case (op)
            0: if (fn <= 5) begin
                put_reg(rd, ref_alu(fn, a, b)); n = 5; tag = "R4/R7";
            end
            1: begin put_reg(rt, ref_alu(0, a, imm)); n = 5; tag = "R2/R4"; end
            2: begin put_reg(rt, ref_alu(5, a, imm)); n = 5; tag = "R4/R7"; end
            3: begin put_reg(rt, ref_alu(2, a, imm)); n = 5; tag = "R4"; end
            4: begin put_reg(rt, ref_alu(3, a, imm)); n = 5; tag = "R4"; end
            5: begin put_reg(rt, ref_alu(4, a, imm)); n = 5; tag = "R4"; end
            16: begin put_reg(rt, mdm[(a + imm) >> 2 & 32'hFF]); n = 5; tag = "R3/R6"; end
            17: begin
                st = 1; sa = a + imm; sd = b; mdm[sa[9:2]] = b; tag = "R3/R6";
            end
            18: begin
                if (a == 0) nxt = npc + (imm << 2);
                tag = "R5";
            end
            default: tag = "R11";
        endcase
        mpc = nxt;
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic build_program();
        int i;
        for (int k = 0; k < MW; k++) imem[k] = enc_i(18, 0, 0, -1);
        // directed prologue
        imem[0]  = enc_i(1, 1, 0, 3);        // r1 = 3
        imem[1]  = enc_i(1, 1, 1, -1);       // r1 = r1 - 1
        imem[2]  = enc_i(18, 0, 1, 1);       // forward taken when r1 == 0 (R5)
        imem[3]  = enc_i(18, 0, 0, -3);      // backward taken to index 1 (R5)
        imem[4]  = enc_i(1, 0, 0, 5);        // write to r0 dropped (R9)
        imem[5]  = enc_i(17, 0, 0, 0);       // store r0 -> expect 0 (R9)
        imem[6]  = enc_i(1, 2, 0, -8);       // sign-extended immediate (R2)
        imem[7]  = enc_i(17, 2, 0, 4);
        imem[8]  = enc_i(1, 3, 0, 64);
        imem[9]  = enc_i(16, 4, 3, -4);      // load, negative offset (R3)
        imem[10] = enc_r(0, 5, 4, 2);        // uses load result at once (R7)
        imem[11] = 32'hFC00_0000;            // unrecognised word (R11)
        imem[12] = enc_r(9, 6, 1, 2);        // bad function code (R11)
        imem[13] = enc_i(17, 5, 0, 8);
        // seeded random body
        for (i = 14; i < 200; i++) begin
            int sel, r1, r2, r3;
            sel = int'($urandom % 8);
            r1  = int'($urandom % 8);
            r2  = int'($urandom % 8);
            r3  = int'($urandom % 8);
            case (sel)
                0, 1: imem[i] = enc_r(int'($urandom % 7), r1, r2, r3);
                2, 3, 7: imem[i] = enc_i(1 + int'($urandom % 5), r1, r2, int'($urandom % 65536));
                4: imem[i] = enc_i(16, r1, 0, int'($urandom % 64) * 4);
                5: imem[i] = enc_i(17, r1, 0, int'($urandom % 64) * 4);
                default: begin
                    int off;
                    off = int'($urandom % 4);
                    if (i + 1 + off > 200) off = 200 - i - 1;
                    imem[i] = enc_i(18, 0, r1, off);
                end
            endcase
        end
        // dump tail: store r1..r7
        for (int k = 1; k <= 7; k++) imem[199 + k] = enc_i(17, k, 0, 32'h300 + 4 * k);
        imem[HALT] = enc_i(18, 0, 0, -1);
    endtask

    initial begin
        void'($urandom(32'd20240417));
        build_program();
        for (int k = 0; k < MW; k++) begin
            dmem[k] = $urandom;
            mdm[k]  = dmem[k];
        end
        for (int k = 0; k < 32; k++) mrg[k] = '0;
        mpc = '0;

        // reset phase (R10)
        repeat (3) @(negedge clk);
        check("R10 pc", imem_addr, 32'd0);
        check("R10 we", {31'd0, dmem_we}, 32'd0);
        rst = 1'b0;

        while (mpc != 32'(HALT * 4) && !dog) begin
            int n;
            bit st;
            logic [31:0] sa, sd;
            string tag;
            check({tag, " pc at fetch"}, imem_addr, mpc);
            model_step(n, st, sa, sd, tag);
            for (int k = 1; k <= n; k++) begin
                if (k == 4 && st) begin
                    check("R6/R8 we", {31'd0, dmem_we}, 32'd1);
                    check("R3 addr", dmem_addr, sa);
                    check("R6/R7/R9 data", dmem_wdata, sd);
                end else if (dmem_we) begin
                    check("R8 stray we", 32'd1, 32'd0);
                end
                @(posedge clk);
                @(negedge clk);
            end
            if (cyc > 20000) dog = 1;
        end
        check("R1/R5 final pc", imem_addr, 32'(HALT * 4));
        if (dog) begin
            total++;
            bad++;
            $display("FAIL watchdog got=%0d exp<=20000", cyc);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        total++;
        bad++;
        $display("FAIL watchdog timeout got=%0d exp=halt", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule